// File: doc/BRIEF.md
# Pin-Swappable SPI Master

This block is a single-slave SPI master whose two data pins have no fixed direction. One configuration bit chooses which pin sends the outgoing serial data and which pin receives the incoming serial data. Board wiring mistakes, or peripherals that expect crossed lines, can then be handled by software without a board change. The master drives a serial clock and an active-low slave select. Each data pin is brought out as a pad-ring triple: an input, an output and an output enable.

Software uses a four-entry register window with a one-cycle write strobe and a combinational read. It sets the pin roles, loads a transmit byte and writes the start location. It then polls the busy flag and reads the received byte. Transfers use SPI mode 0, most significant bit first, with a fixed word width. The serial clock half-period is a whole number of system clock cycles set by a parameter.

Top module: `swap_spi_master`

## Requirements
- R1: After reset the swap bit reads 0, `ss_n` is 1, `sclk` is 0 and the busy flag reads 0.
- R2: With the swap bit at 0, `pin_b_oe`=1 and `pin_a_oe`=0, outgoing data appears on `pin_b_o`, and incoming data is taken from `pin_a_i` only.
- R3: With the swap bit at 1, `pin_a_oe`=1 and `pin_b_oe`=0, outgoing data appears on `pin_a_o`, and incoming data is taken from `pin_b_i` only.
- R4: A transfer has exactly DATA_W rising `sclk` edges. The outgoing data is sent MSB first, and it changes only when `sclk` falls, so it is stable at each rising edge.
- R5: Incoming data is sampled on each rising `sclk` edge, MSB first. The assembled word reads back at address 3 once busy has cleared.
- R6: `sclk` idles low. During a transfer every high and low phase lasts exactly DIV_HALF system clock cycles, including the phase from the fall of `ss_n` to the first rising edge.
- R7: `ss_n` is low for the whole transfer and high when idle. `sclk` is never high while `ss_n` is high.
- R8: Busy (address 2, bit 0) reads 1 from the edge that accepts the start write until the edge where `sclk` falls after the last sample. At that edge busy, `ss_n` and the received word update together.
- R9: A write to the swap bit (address 0, bit 0) while busy is ignored: the read-back value and the pin enables stay unchanged.
- R10: A start write (any write to address 2) while busy neither restarts nor lengthens the current transfer.
- R11: Address 1 reads back the last written transmit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address: 0 swap, 1 transmit, 2 start/busy, 3 receive |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Slave select, active low |
| pin_a_i | input | 1 | Data pin A, pad input |
| pin_a_o | output | 1 | Data pin A, pad output |
| pin_a_oe | output | 1 | Data pin A, output enable |
| pin_b_i | input | 1 | Data pin B, pad input |
| pin_b_o | output | 1 | Data pin B, pad output |
| pin_b_oe | output | 1 | Data pin B, output enable |

## Verification
The bench sweeps every transmit word under both pin mappings. On the pin that is not the selected input, it drives the inverse of the slave's data. A multiplexer that listens to the wrong pad therefore returns a complemented word instead of passing by chance. Every clock phase is timed in system cycles, so a divider that is off by one, or a first phase that is shortened, shows up as a wrong gap. In some transfers the bench writes to the swap bit and the start location partway through. A design that accepts either write would flip the drivers in the middle of a word, or stretch the frame past DATA_W rising edges.

// File: rtl/swap_spi_pkg.sv
package swap_spi_pkg;
   localparam int unsigned REG_ADDR_W = 2;
   localparam logic [REG_ADDR_W-1:0] ADDR_SWAP = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_TXW  = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADDR_RXW  = 2'd3;

   typedef enum logic {
      ROLE_B_DRIVES = 1'b0,
      ROLE_A_DRIVES = 1'b1
   } pin_role_e;
endpackage

// File: rtl/swap_spi_regs.sv
module swap_spi_regs #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic [DATA_W-1:0] rx_word,
   output swap_spi_pkg::pin_role_e role,
   output logic [DATA_W-1:0] tx_word,
   output logic              start
);
   import swap_spi_pkg::*;

   localparam int unsigned LOW_W = REG_ADDR_W;

   logic [LOW_W-1:0] sel;
   logic             hit;

   assign sel = reg_addr[LOW_W-1:0];

   generate
      if (ADDR_W > LOW_W) begin : g_wide_addr
         assign hit = (reg_addr[ADDR_W-1:LOW_W] == '0);
      end else begin : g_exact_addr
         assign hit = 1'b1;
      end
   endgenerate

   assign start = reg_we && hit && (sel == ADDR_CTRL) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         role    <= ROLE_B_DRIVES;
         tx_word <= '0;
      end else if (reg_we && hit) begin
         if (sel == ADDR_SWAP && !busy) begin
            role <= pin_role_e'(reg_wdata[0]);
         end
         if (sel == ADDR_TXW) begin
            tx_word <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         unique case (sel)
            ADDR_SWAP: reg_rdata[0] = (role == ROLE_A_DRIVES);
            ADDR_TXW:  reg_rdata    = tx_word;
            ADDR_CTRL: reg_rdata[0] = busy;
            ADDR_RXW:  reg_rdata    = rx_word;
            default:   reg_rdata    = '0;
         endcase
      end
   end
endmodule

// File: rtl/swap_spi_clkdiv.sv
module swap_spi_clkdiv #(
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV_HALF == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int unsigned CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt;

         assign tick = run && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || tick) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/swap_spi_shifter.sv
module swap_spi_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              tick,
   input  logic              miso,
   output logic              mosi,
   output logic              sclk,
   output logic              busy,
   output logic [DATA_W-1:0] rx_word
);
   localparam int unsigned BIT_W = $clog2(DATA_W + 1);
   localparam logic [BIT_W-1:0] FULL = BIT_W'(DATA_W);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [BIT_W-1:0]  nbits;

   assign mosi = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         nbits   <= '0;
         sclk    <= 1'b0;
         busy    <= 1'b0;
         rx_word <= '0;
      end else if (start) begin
         tx_sh <= tx_word;
         nbits <= '0;
         sclk  <= 1'b0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
            nbits <= nbits + 1'b1;
         end else begin
            sclk <= 1'b0;
            if (nbits == FULL) begin
               busy    <= 1'b0;
               rx_word <= rx_sh;
            end else begin
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/swap_spi_pinmux.sv
module swap_spi_pinmux (
   input  swap_spi_pkg::pin_role_e role,
   input  logic       mosi,
   output logic       miso,
   input  logic [1:0] pad_i,
   output logic [1:0] pad_o,
   output logic [1:0] pad_oe
);
   import swap_spi_pkg::*;

   logic a_drives;
   assign a_drives = (role == ROLE_A_DRIVES);

   generate
      for (genvar g = 0; g < 2; g++) begin : g_pad
         localparam bit IS_A = (g == 0);
         assign pad_oe[g] = (a_drives == IS_A);
         assign pad_o[g]  = pad_oe[g] & mosi;
      end
   endgenerate

   assign miso = a_drives ? pad_i[1] : pad_i[0];
endmodule

// File: rtl/swap_spi_master.sv
module swap_spi_master #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DIV_HALF = 4,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sclk,
   output logic              ss_n,
   input  logic              pin_a_i,
   output logic              pin_a_o,
   output logic              pin_a_oe,
   input  logic              pin_b_i,
   output logic              pin_b_o,
   output logic              pin_b_oe
);
   import swap_spi_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("swap_spi_master: DATA_W must be at least 2");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("swap_spi_master: DIV_HALF must be at least 1");
      end
      if (ADDR_W < REG_ADDR_W) begin : g_bad_addr
         $error("swap_spi_master: ADDR_W too narrow for the register window");
      end
   endgenerate

   pin_role_e         role;
   logic [DATA_W-1:0] tx_word;
   logic [DATA_W-1:0] rx_word;
   logic              start;
   logic              busy;
   logic              tick;
   logic              mosi;
   logic              miso;
   logic [1:0]        pad_o;
   logic [1:0]        pad_oe;

   swap_spi_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .rx_word   (rx_word),
      .role      (role),
      .tx_word   (tx_word),
      .start     (start)
   );

   swap_spi_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   swap_spi_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_word (tx_word),
      .tick    (tick),
      .miso    (miso),
      .mosi    (mosi),
      .sclk    (sclk),
      .busy    (busy),
      .rx_word (rx_word)
   );

   swap_spi_pinmux u_mux (
      .role   (role),
      .mosi   (mosi),
      .miso   (miso),
      .pad_i  ({pin_b_i, pin_a_i}),
      .pad_o  (pad_o),
      .pad_oe (pad_oe)
   );

   assign ss_n     = !busy;
   assign pin_a_o  = pad_o[0];
   assign pin_a_oe = pad_oe[0];
   assign pin_b_o  = pad_o[1];
   assign pin_b_oe = pad_oe[1];
endmodule

// File: rtl/swap_spi_checker.sv
module swap_spi_checker (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic ss_n,
   input logic pin_a_o,
   input logic pin_a_oe,
   input logic pin_b_o,
   input logic pin_b_oe
);
   logic drive_val;
   assign drive_val = pin_a_oe ? pin_a_o : pin_b_o;

   assert_one_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pin_a_oe, pin_b_oe}) == 1);

   assert_roles_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n |=> $stable(pin_a_oe) && $stable(pin_b_oe));

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(drive_val));

   assert_idle_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> !sclk);

   assert_frame_opens_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ss_n) |-> !sclk);

   assert_edge_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !ss_n);
endmodule

bind swap_spi_master swap_spi_checker u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk     (sclk),
   .ss_n     (ss_n),
   .pin_a_o  (pin_a_o),
   .pin_a_oe (pin_a_oe),
   .pin_b_o  (pin_b_o),
   .pin_b_oe (pin_b_oe)
);

// File: tb/swap_spi_master_bench.sv
module swap_spi_master_bench;
   localparam int W   = 8;
   localparam int DIV = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   reg_addr = '0;
   logic         reg_we = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         sclk, ss_n;
   logic         pin_a_i = 1'b0, pin_b_i = 1'b0;
   logic         pin_a_o, pin_a_oe, pin_b_o, pin_b_oe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   swap_spi_master #(.DATA_W(W), .DIV_HALF(DIV), .ADDR_W(2)) u_swap_spi_master (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .ss_n(ss_n),
      .pin_a_i(pin_a_i), .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe),
      .pin_b_i(pin_b_i), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic check_roles(input bit swap);
      if (!swap) begin
         chk(pin_b_oe == 1'b1 && pin_a_oe == 1'b0, "R2", "oe pattern {a,b}",
             {pin_a_oe, pin_b_oe}, 1);
      end else begin
         chk(pin_a_oe == 1'b1 && pin_b_oe == 1'b0, "R3", "oe pattern {a,b}",
             {pin_a_oe, pin_b_oe}, 2);
      end
   endtask

   task automatic drive_in(input bit swap, input bit v);
      if (swap) begin pin_b_i = v; pin_a_i = ~v; end
      else      begin pin_a_i = v; pin_b_i = ~v; end
   endtask

   task automatic transfer(input bit swap, input logic [W-1:0] tx,
                           input logic [W-1:0] sb, input bit meddle);
      logic [W-1:0] got_out;
      logic [W-1:0] rv;
      int  rises, falls, last_edge, cyc;
      bit  prev_sclk, gap_ok, ss_ok, frame_bad;
      got_out = '0; rises = 0; falls = 0; gap_ok = 1; ss_ok = 1;
      drive_in(swap, sb[W-1]);
      @(negedge clk);
      reg_addr = 2'd2; reg_wdata = '0; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      rd(2'd2, rv);
      chk(rv[0] == 1'b1, "R8", "busy after start", rv[0], 1);
      chk(ss_n == 1'b0, "R7", "ss_n after start", ss_n, 0);
      prev_sclk = sclk; last_edge = 0; cyc = 0;
      frame_bad = 0;
      while (ss_n == 1'b0 && cyc < 400) begin
         if (meddle && cyc == 4) begin
            reg_addr = 2'd0; reg_wdata = {7'd0, ~swap}; reg_we = 1'b1;
         end else if (meddle && cyc == 5) begin
            reg_addr = 2'd2; reg_we = 1'b1;
         end else if (meddle && cyc == 6) begin
            reg_we = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (sclk != prev_sclk || (ss_n && prev_sclk)) begin
            if (cyc - last_edge != DIV) gap_ok = 0;
            last_edge = cyc;
            if (!prev_sclk) begin
               rises++;
               got_out = {got_out[W-2:0], swap ? pin_a_o : pin_b_o};
               if (ss_n) ss_ok = 0;
            end else begin
               falls++;
               if (falls < W) drive_in(swap, sb[W-1-falls]);
            end
         end
         if (!ss_n && !(swap ? pin_a_oe : pin_b_oe)) frame_bad = 1;
         prev_sclk = sclk;
      end
      reg_we = 1'b0;
      chk(rises == W, meddle ? "R10" : "R4", "rising edge count", rises, W);
      chk(got_out == tx, "R4", "outgoing word", got_out, tx);
      chk(gap_ok, "R6", "phase length ok", gap_ok, 1);
      chk(ss_ok && !sclk, "R7", "ss low at every rise, sclk idle", ss_ok, 1);
      chk(!frame_bad, "R9", "driver role held in frame", frame_bad, 0);
      rd(2'd2, rv);
      chk(rv[0] == 1'b0, "R8", "busy cleared with ss_n high", rv[0], 0);
      rd(2'd3, rv);
      chk(rv == sb, "R5", "received word", rv, sb);
      if (meddle) begin
         rd(2'd0, rv);
         chk(rv[0] == swap, "R9", "swap bit after busy write", rv[0], swap);
         check_roles(swap);
         repeat (2 * DIV + 2) @(negedge clk);
         chk(ss_n == 1'b1, "R10", "no second frame", ss_n, 1);
      end
   endtask

   task automatic run_all();
      logic [W-1:0] rv;
      repeat (3) @(negedge clk);
      chk(ss_n == 1'b1, "R1", "ss_n in reset", ss_n, 1);
      chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, rv);
      chk(rv[0] == 1'b0, "R1", "swap bit after reset", rv[0], 0);
      rd(2'd2, rv);
      chk(rv[0] == 1'b0, "R1", "busy after reset", rv[0], 0);
      check_roles(1'b0);
      for (int s = 0; s < 2; s++) begin
         wr(2'd0, W'(s));
         rd(2'd0, rv);
         chk(rv[0] == s[0], "R3", "swap bit readback", rv[0], s);
         check_roles(s[0]);
         for (int v = 0; v < 256; v++) begin
            logic [W-1:0] tx, sb;
            tx = W'(v);
            sb = W'((v * 37 + 11 + s * 90) & 255);
            wr(2'd1, tx);
            rd(2'd1, rv);
            chk(rv == tx, "R11", "tx readback", rv, tx);
            transfer(s[0], tx, sb, (v % 32) == 5);
         end
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule